// File: doc/BRIEF.md
# Asynchronous Serial Controller Register Interface

This block is the processor-side register file of an asynchronous serial controller. It sits on an 8-bit bus with a select, read and write strobes, and a line that picks the control/status address or the data address. Control writes are steered by a small sequencer. The first control write after reset, or after a software reset command, is stored as the mode word. Every later control write is stored as the command word.

The mode word is decoded into line-format outputs for the transmitter and receiver: clock divide factor, character length, parity enable and sense, and stop length in half-bit units. The command word drives the active-low terminal-ready output, clears the error flags and can return the sequencer to mode entry. On the data path, the block holds one byte for the transmitter and one byte for the receiver, each with a ready flag. It also keeps sticky parity, overrun and framing error flags, and it assembles a status byte for the processor to read.

Top module: `sercfg_regs`

## Requirements
- R1: After reset, or after a software reset command, the first control write (sel=1, wr=1, ctl=1) loads the mode word. Every later control write is a command word and leaves the decoded line format unchanged.
- R2: Mode bits [1:0] give the clock divide: 01 gives 1, 10 gives 16 and 11 gives 64. The value 00 (synchronous) leaves `cfg_valid` low; otherwise `cfg_valid` is high once a mode word is loaded.
- R3: Mode bits [3:2], read as an unsigned code c, give a character length of 5+c bits.
- R4: Mode bit 4 enables parity. Mode bit 5 set selects even parity.
- R5: Mode bits [7:6] give the stop length in half bits: 00 and 01 give 2, 10 gives 3 and 11 gives 4.
- R6: `dtr_n` is high after reset and equals the inverse of command bit 2 after each command write.
- R7: A control read returns the status byte. The layout is: bit 0 transmit ready, bit 1 receive ready, bit 2 transmitter empty, bit 3 parity error, bit 4 overrun, bit 5 framing error, bit 6 zero, bit 7 the `dsr` input level.
- R8: A data write stores the byte on `tx_byte`, raises `tx_pending` and clears transmit ready. A `tx_take` pulse clears `tx_pending` and sets transmit ready.
- R9: The transmitter-empty status bit is high only when `tx_idle` is high and no byte is pending.
- R10: An `rx_load` pulse latches `rx_in` and sets receive ready. A data read returns that byte and clears receive ready, unless a new `rx_load` arrives in the same cycle.
- R11: An `rx_load` while receive ready is set and no data read is under way sets the sticky overrun flag, and the new byte replaces the old one.
- R12: `rx_perr` and `rx_ferr` pulses set sticky status bits 3 and 5. A command with bit 4 set clears all three error flags, and a set in the same cycle wins over the clear.
- R13: A command with bit 6 set returns the sequencer to mode entry, drives `cfg_valid` low and `dtr_n` high, and clears the error flags. All other bits of that write are ignored.
- R14: Strobes with `sel` low have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Block select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ctl | input | 1 | 1 selects control/status, 0 selects data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| tx_byte | output | 8 | Byte held for the transmitter |
| tx_pending | output | 1 | Held byte not yet taken |
| tx_take | input | 1 | Transmitter takes the held byte |
| tx_idle | input | 1 | Transmitter shift path is empty |
| rx_in | input | 8 | Byte assembled by the receiver |
| rx_load | input | 1 | Receiver delivers `rx_in` |
| rx_perr | input | 1 | Parity error pulse |
| rx_ferr | input | 1 | Framing error pulse |
| dsr | input | 1 | Modem data-set-ready level |
| cfg_valid | output | 1 | An asynchronous mode word is loaded |
| clk_div | output | 7 | Clock divide factor |
| char_len | output | 4 | Character length in bits |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| stop_halves | output | 3 | Stop length in half bits |
| dtr_n | output | 1 | Terminal ready, active low |

## Verification
The hardest situation to reach is a decode check on all 256 mode words. Only one control write per reset cycle can reach the mode register. The stimulus gets there by alternating each mode write with a software reset command, and after each mode write it issues a neutral command to show that the decode holds. The other hard cases are two same-cycle collisions: a receiver delivery during a data read, and an error pulse during an error-clear command. Both are built by driving the two inputs within the same negedge window.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
   typedef enum logic {SEQ_MODE = 1'b0, SEQ_CMD = 1'b1} seq_e;

   localparam int ST_TXRDY = 0;
   localparam int ST_RXRDY = 1;
   localparam int ST_TXE   = 2;
   localparam int ST_PERR  = 3;
   localparam int ST_OVR   = 4;
   localparam int ST_FERR  = 5;
   localparam int ST_DSR   = 7;

   localparam int CMD_DTR  = 2;
   localparam int CMD_ECLR = 4;
   localparam int CMD_SRST = 6;

   localparam int ERR_PAR  = 0;
   localparam int ERR_OVR  = 1;
   localparam int ERR_FRM  = 2;
   localparam int ERR_N    = 3;
endpackage

// File: rtl/sercfg_mode_dec.sv
module sercfg_mode_dec #(
   parameter int DIV_MID  = 16,
   parameter int DIV_MAX  = 64,
   parameter int DIV_W    = 7,
   parameter int MIN_CHAR = 5,
   parameter int LEN_W    = 4
) (
   input  logic [7:0]       mode,
   output logic [DIV_W-1:0] div,
   output logic [LEN_W-1:0] len,
   output logic             par_on,
   output logic             par_ev,
   output logic [2:0]       stop_h
);
   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
   localparam logic [DIV_W-1:0] DIV_M   = DIV_W'(DIV_MID);
   localparam logic [DIV_W-1:0] DIV_X   = DIV_W'(DIV_MAX);
   localparam logic [LEN_W-1:0] LEN_B   = LEN_W'(MIN_CHAR);

   always_comb begin
      unique case (mode[1:0])
         2'b10:   div = DIV_M;
         2'b11:   div = DIV_X;
         default: div = DIV_ONE;
      endcase
   end

   assign len    = LEN_B + LEN_W'(mode[3:2]);
   assign par_on = mode[4];
   assign par_ev = mode[5];

   always_comb begin
      unique case (mode[7:6])
         2'b10:   stop_h = 3'd3;
         2'b11:   stop_h = 3'd4;
         default: stop_h = 3'd2;
      endcase
   end
endmodule

// File: rtl/sercfg_err_bank.sv
module sercfg_err_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] flag
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[i] <= 1'b0;
         else if (set[i]) flag[i] <= 1'b1;
         else if (clr)    flag[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
   import sercfg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_MID  = 16,
   parameter int DIV_MAX  = 64,
   parameter int MIN_CHAR = 5,
   parameter int DIV_W    = $clog2(DIV_MAX + 1),
   parameter int LEN_W    = $clog2(MIN_CHAR + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rd,
   input  logic              wr,
   input  logic              ctl,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_pending,
   input  logic              tx_take,
   input  logic              tx_idle,
   input  logic [DATA_W-1:0] rx_in,
   input  logic              rx_load,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              dsr,
   output logic              cfg_valid,
   output logic [DIV_W-1:0]  clk_div,
   output logic [LEN_W-1:0]  char_len,
   output logic              par_en,
   output logic              par_even,
   output logic [2:0]        stop_halves,
   output logic              dtr_n
);
   if (DATA_W != 8) begin : g_bad_width
      $error("sercfg_regs: DATA_W must be 8");
   end
   if (DIV_MID <= 1 || DIV_MAX <= DIV_MID) begin : g_bad_div
      $error("sercfg_regs: need 1 < DIV_MID < DIV_MAX");
   end

   seq_e              seq;
   logic [7:0]        mode_q;
   logic [7:0]        cmd_q;
   logic              mode_ok;
   logic              rx_full;
   logic [DATA_W-1:0] rx_q;
   logic [ERR_N-1:0]  err_set;
   logic [ERR_N-1:0]  err;
   logic [7:0]        stat;
   logic              await_cmd;

   logic wr_ctl, wr_dat, rd_dat, rd_ctl, do_cmd, err_clr;
   assign wr_ctl  = sel & wr & ctl;
   assign wr_dat  = sel & wr & ~ctl;
   assign rd_dat  = sel & rd & ~ctl;
   assign rd_ctl  = sel & rd & ctl;
   assign await_cmd = (seq == SEQ_CMD);
   assign do_cmd  = wr_ctl & await_cmd;
   assign err_clr = do_cmd & (wdata[CMD_ECLR] | wdata[CMD_SRST]);

   // control sequencer: mode word first, then command words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq     <= SEQ_MODE;
         mode_q  <= '0;
         cmd_q   <= '0;
         mode_ok <= 1'b0;
      end else if (wr_ctl) begin
         if (seq == SEQ_MODE) begin
            mode_q  <= wdata[7:0];
            mode_ok <= 1'b1;
            seq     <= SEQ_CMD;
         end else if (wdata[CMD_SRST]) begin
            cmd_q   <= '0;
            mode_ok <= 1'b0;
            seq     <= SEQ_MODE;
         end else begin
            cmd_q   <= wdata[7:0];
         end
      end
   end

   // transmit holding byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte    <= '0;
         tx_pending <= 1'b0;
      end else if (wr_dat) begin
         tx_byte    <= wdata;
         tx_pending <= 1'b1;
      end else if (tx_take) begin
         tx_pending <= 1'b0;
      end
   end

   // receive holding byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         rx_full <= 1'b0;
      end else if (rx_load) begin
         rx_q    <= rx_in;
         rx_full <= 1'b1;
      end else if (rd_dat) begin
         rx_full <= 1'b0;
      end
   end

   always_comb begin
      err_set          = '0;
      err_set[ERR_PAR] = rx_perr;
      err_set[ERR_OVR] = rx_load & rx_full & ~rd_dat;
      err_set[ERR_FRM] = rx_ferr;
   end

   sercfg_err_bank #(.N(ERR_N)) u_err (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (err_set),
      .clr  (err_clr),
      .flag (err)
   );

   sercfg_mode_dec #(
      .DIV_MID (DIV_MID),
      .DIV_MAX (DIV_MAX),
      .DIV_W   (DIV_W),
      .MIN_CHAR(MIN_CHAR),
      .LEN_W   (LEN_W)
   ) u_dec (
      .mode  (mode_q),
      .div   (clk_div),
      .len   (char_len),
      .par_on(par_en),
      .par_ev(par_even),
      .stop_h(stop_halves)
   );

   always_comb begin
      stat           = '0;
      stat[ST_TXRDY] = ~tx_pending;
      stat[ST_RXRDY] = rx_full;
      stat[ST_TXE]   = tx_idle & ~tx_pending;
      stat[ST_PERR]  = err[ERR_PAR];
      stat[ST_OVR]   = err[ERR_OVR];
      stat[ST_FERR]  = err[ERR_FRM];
      stat[ST_DSR]   = dsr;
   end

   always_comb begin
      if (rd_ctl)      rdata = stat;
      else if (rd_dat) rdata = rx_q;
      else             rdata = '0;
   end

   assign cfg_valid = mode_ok & (mode_q[1:0] != 2'b00);
   assign dtr_n     = ~cmd_q[CMD_DTR];
endmodule

// File: rtl/sercfg_regs_chk.sv
module sercfg_regs_chk #(
   parameter int DIV_W = 7,
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             rd,
   input logic             wr,
   input logic             ctl,
   input logic [7:0]       wdata,
   input logic [7:0]       rdata,
   input logic [7:0]       stat,
   input logic             await_cmd,
   input logic             rx_load,
   input logic             dsr,
   input logic             tx_pending,
   input logic [7:0]       tx_byte,
   input logic             cfg_valid,
   input logic             dtr_n,
   input logic [DIV_W-1:0] clk_div,
   input logic [LEN_W-1:0] char_len
);
   AST_CMD_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ctl && await_cmd && !wdata[6]) |=> ($stable(clk_div) && $stable(char_len))); // R1

   AST_DTR_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ctl && await_cmd && !wdata[6]) |=> (dtr_n == !$past(wdata[2]))); // R6

   AST_DSR_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rd && ctl) |-> (rdata[7] == dsr && rdata[6] == 1'b0)); // R7

   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && !ctl) |=> (tx_pending && !stat[0])); // R8

   AST_RX_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> stat[1]); // R10

   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ctl && await_cmd && wdata[6]) |=> (!cfg_valid && dtr_n && !await_cmd)); // R13

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> ($stable(tx_byte) && $stable(dtr_n))); // R14
endmodule

bind sercfg_regs sercfg_regs_chk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel       (sel),
   .rd        (rd),
   .wr        (wr),
   .ctl       (ctl),
   .wdata     (wdata),
   .rdata     (rdata),
   .stat      (stat),
   .await_cmd (await_cmd),
   .rx_load   (rx_load),
   .dsr       (dsr),
   .tx_pending(tx_pending),
   .tx_byte   (tx_byte),
   .cfg_valid (cfg_valid),
   .dtr_n     (dtr_n),
   .clk_div   (clk_div),
   .char_len  (char_len)
);

// File: tb/sercfg_regs_test.sv
`timescale 1ns/1ps
module sercfg_regs_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 0, rd = 0, wr = 0, ctl = 0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, tx_byte;
   logic       tx_pending, tx_take = 0, tx_idle = 1;
   logic [7:0] rx_in = '0;
   logic       rx_load = 0, rx_perr = 0, rx_ferr = 0, dsr = 0;
   logic       cfg_valid, par_en, par_even, dtr_n;
   logic [6:0] clk_div;
   logic [3:0] char_len;
   logic [2:0] stop_halves;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sercfg_regs uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .ctl(ctl),
      .wdata(wdata), .rdata(rdata), .tx_byte(tx_byte), .tx_pending(tx_pending),
      .tx_take(tx_take), .tx_idle(tx_idle), .rx_in(rx_in), .rx_load(rx_load),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .dsr(dsr), .cfg_valid(cfg_valid),
      .clk_div(clk_div), .char_len(char_len), .par_en(par_en),
      .par_even(par_even), .stop_halves(stop_halves), .dtr_n(dtr_n)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic c, input logic [7:0] v, input logic s = 1'b1);
      @(negedge clk);
      sel = s; wr = 1; ctl = c; wdata = v;
      @(negedge clk);
      sel = 0; wr = 0;
   endtask

   task automatic bus_rd(input logic c, output logic [7:0] v);
      @(negedge clk);
      sel = 1; rd = 1; ctl = c;
      #1 v = rdata;
      @(negedge clk);
      sel = 0; rd = 0;
   endtask

   task automatic rx_deliver(input logic [7:0] b);
      @(negedge clk);
      rx_load = 1; rx_in = b;
      @(negedge clk);
      rx_load = 0;
   endtask

   function automatic int exp_div(input int m);
      case (m & 3)
         2: return 16;
         3: return 64;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_stop(input int m);
      int s = (m >> 6) & 3;
      return (s < 2) ? 2 : s + 1;
   endfunction

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // reset state
      chk("R6 reset dtr_n", dtr_n, 1);
      chk("R2 reset cfg_valid", cfg_valid, 0);
      bus_rd(1, v);
      chk("R7 reset status", v, 8'h05);

      // strobes without select
      bus_wr(1, 8'h4E, 1'b0);
      chk("R14 ignored control write", cfg_valid, 0);
      bus_wr(0, 8'h99, 1'b0);
      chk("R14 ignored data write", tx_pending, 0);
      chk("R14 ignored data byte", tx_byte, 0);

      // every mode word, each followed by a neutral command and a soft reset
      for (int m = 0; m < 256; m++) begin
         bus_wr(1, 8'(m));
         chk("R2 cfg_valid", cfg_valid, ((m & 3) != 0) ? 1 : 0);
         if ((m & 3) != 0) chk("R2 clk_div", clk_div, exp_div(m));
         chk("R3 char_len", char_len, 5 + ((m >> 2) & 3));
         chk("R4 par_en", par_en, (m >> 4) & 1);
         chk("R4 par_even", par_even, (m >> 5) & 1);
         chk("R5 stop_halves", stop_halves, exp_stop(m));
         bus_wr(1, 8'h8B & ~8'h04);
         chk("R1 command keeps len", char_len, 5 + ((m >> 2) & 3));
         chk("R1 command keeps stop", stop_halves, exp_stop(m));
         bus_wr(1, 8'h40);
         chk("R13 soft reset cfg_valid", cfg_valid, 0);
      end

      // DTR follows every command value without soft reset
      bus_wr(1, 8'h4E);
      for (int c = 0; c < 256; c++) begin
         if (((c >> 6) & 1) == 0) begin
            bus_wr(1, 8'(c));
            chk("R6 dtr_n", dtr_n, ((c >> 2) & 1) ? 0 : 1);
         end
      end
      bus_wr(1, 8'h10);

      // DSR reporting
      for (int d = 0; d < 2; d++) begin
         dsr = d[0];
         bus_rd(1, v);
         chk("R7 status dsr", v, (d << 7) | 8'h05);
      end
      dsr = 0;

      // transmit path
      bus_wr(0, 8'hA5);
      chk("R8 tx_byte", tx_byte, 8'hA5);
      chk("R8 tx_pending", tx_pending, 1);
      bus_rd(1, v);
      chk("R8 txrdy low", v[0], 0);
      chk("R9 txe low while pending", v[2], 0);
      @(negedge clk); tx_take = 1; tx_idle = 0;
      @(negedge clk); tx_take = 0;
      bus_rd(1, v);
      chk("R8 txrdy after take", v[0], 1);
      chk("R9 txe low while shifting", v[2], 0);
      tx_idle = 1;
      bus_rd(1, v);
      chk("R9 txe high when idle", v[2], 1);

      // receive path
      rx_deliver(8'h3C);
      bus_rd(1, v);
      chk("R10 rxrdy set", v[1], 1);
      bus_rd(0, v);
      chk("R10 data read", v, 8'h3C);
      bus_rd(1, v);
      chk("R10 rxrdy cleared", v[1], 0);
      chk("R11 no overrun", v[4], 0);

      // overrun
      rx_deliver(8'h11);
      rx_deliver(8'h22);
      bus_rd(1, v);
      chk("R11 overrun set", v[4], 1);
      bus_rd(0, v);
      chk("R11 newer byte kept", v, 8'h22);
      bus_wr(1, 8'h10);
      bus_rd(1, v);
      chk("R12 clear overrun", v[4], 0);

      // delivery during a data read
      rx_deliver(8'h33);
      @(negedge clk);
      sel = 1; rd = 1; ctl = 0; rx_load = 1; rx_in = 8'h44;
      #1 chk("R10 read during load", rdata, 8'h33);
      @(negedge clk);
      sel = 0; rd = 0; rx_load = 0;
      bus_rd(1, v);
      chk("R10 rxrdy kept by load", v[1], 1);
      chk("R11 no overrun on read", v[4], 0);
      bus_rd(0, v);
      chk("R10 second byte", v, 8'h44);

      // parity and framing flags
      @(negedge clk); rx_perr = 1;
      @(negedge clk); rx_perr = 0; rx_ferr = 1;
      @(negedge clk); rx_ferr = 0;
      bus_rd(1, v);
      chk("R12 parity+framing flags", v & 8'h38, 8'h28);
      bus_wr(1, 8'h10);
      bus_rd(1, v);
      chk("R12 flags cleared", v & 8'h38, 8'h00);
      @(negedge clk);
      sel = 1; wr = 1; ctl = 1; wdata = 8'h10; rx_perr = 1;
      @(negedge clk);
      sel = 0; wr = 0; rx_perr = 0;
      bus_rd(1, v);
      chk("R12 set wins over clear", v[3], 1);

      // soft reset with other bits present
      bus_wr(1, 8'h04);
      chk("R6 dtr asserted", dtr_n, 0);
      @(negedge clk); rx_ferr = 1;
      @(negedge clk); rx_ferr = 0;
      bus_wr(1, 8'h44);
      chk("R13 dtr released", dtr_n, 1);
      chk("R13 cfg_valid low", cfg_valid, 0);
      bus_rd(1, v);
      chk("R13 errors cleared", v & 8'h38, 8'h00);
      bus_wr(1, 8'h0D);
      chk("R13 next write is mode", cfg_valid, 1);
      chk("R13 mode div", clk_div, 1);
      chk("R13 mode len", char_len, 8);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule